// File: doc/BRIEF.md
# Flash Program-and-Verify Sequencer

This block sits on the host side of a parallel flash device and writes a run of consecutive byte locations through the device's command register. After a start pulse it takes a base address and a location count. For each location it asks a data source for the byte once. It then issues the program-setup command, the address/data write and the verify command. It waits out the settling time the device needs and reads the location back.

When the read-back matches, the sequencer moves to the next address. When it does not match, the whole program/verify round is repeated with the same address and data, up to a fixed number of attempts. Once every location has passed, the device is returned to read mode and a one-cycle done pulse is given. If a location exhausts its attempts, the sequencer stops at once, raises a sticky fail flag and reports that address.

The flash side is an abstract single-cycle bus. A write strobe carries an address and a data word. A read strobe returns data on the cycle after it. Command codes sit in the low 8 bits of the data word and the upper bits are zero.

Top module: `pvs_seq`

## Requirements
- R1: A start pulse accepted while idle with count N>0 and base B visits the addresses B, B+1, …, B+N-1 in ascending order. For each one, the setup command 40h is written, and in the next cycle a write carries the location's address and data.
- R2: Each program write is followed in the very next cycle by a write of the verify command C0h. No read is issued unless a verify command has come before it.
- R3: The read strobe comes exactly SETTLE_CYC+1 cycles after the verify-command write. SETTLE_CYC is 6000 ns × CLK_MHZ / 1000, rounded up (1200 at 200 MHz). Read data is compared on the cycle after the read strobe.
- R4: The data source is requested (src_req with src_addr = location address) exactly once per location. Retries reuse the held byte, and a matching read-back advances to the next location.
- R5: A mismatching read-back repeats the setup/program/verify/read round at the same address with the same data. At most MAX_TRIES (25) program writes are made per location.
- R6: After MAX_TRIES mismatches the sequencer stops with no further bus cycle and no read-mode write. It sets fail=1 and fail_addr to that location, drops busy and gives no done. fail stays set until the next accepted start clears it.
- R7: When the last location passes, the read-mode command 00h is written. done is then high for exactly one cycle, and busy falls in the same cycle that done falls.
- R8: A start with count 0 makes one bus cycle only, the 00h write, followed by done.
- R9: A start pulse while busy is ignored and the run in progress is not disturbed.
- R10: During and after reset, busy, done, fail, src_req, bus_we and bus_rd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| base_addr | input | AW | First flash address of the run |
| length | input | LW | Number of locations to program |
| src_req | output | 1 | Request for the byte of src_addr |
| src_addr | output | AW | Address whose byte is requested |
| src_valid | input | 1 | Source byte valid, ends the request |
| src_data | input | DW | Byte to be programmed |
| bus_we | output | 1 | Flash write strobe |
| bus_rd | output | 1 | Flash read strobe |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | DW | Flash write data / command |
| bus_rdata | input | DW | Flash read data, valid the cycle after bus_rd |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after a successful run |
| fail | output | 1 | Sticky: a location exhausted its attempts |
| fail_addr | output | AW | Address of the failing location |

## Verification
A settle counter that runs short or long shows up within one attempt as a read strobe that is off its exact distance from the verify write. That distance is about 1200 cycles at the default clock. An attempt counter that is off by one shows as 24 or 26 program writes at a location that never verifies. It also shows as a wrongly passed or failed location that needs exactly 25 attempts. A corrupted held byte or address appears on the next program write as a wrong stored value. A wrong end-of-run state shows as a missing 00h write, a missing or doubled done pulse, or a fail flag that survives the next start.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_SETUP,
    S_PROG,
    S_VCMD,
    S_SETTLE,
    S_READ,
    S_CMP,
    S_RDMODE,
    S_DONE
  } pvs_state_e;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_SETUP  = 8'h40;
  localparam logic [7:0] OP_VERIFY = 8'hC0;

endpackage

// File: rtl/pvs_settle_timer.sv
module pvs_settle_timer #(
  parameter int CYC = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int W = (CYC > 1) ? $clog2(CYC + 1) : 1;
  localparam logic [W-1:0] LAST = W'(CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == LAST);

  // R3: the count window never overshoots
  p_cnt_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));
  // R3: one expiry per settle window
  p_expire_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

endmodule

// File: rtl/pvs_try_counter.sv
module pvs_try_counter #(
  parameter int MAX = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] LAST = W'(MAX - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST);

  // R5: failed attempts recorded never reach the limit itself
  p_try_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < W'(MAX));

endmodule

// File: rtl/pvs_bus_drive.sv
module pvs_bus_drive
  import pvs_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  pvs_state_e    state,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_data,
  output logic          bus_we,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  always_comb begin
    bus_we    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    bus_addr  = loc_addr;
    unique case (state)
      S_SETUP:  begin bus_we = 1'b1; bus_wdata = DW'(OP_SETUP);  end
      S_PROG:   begin bus_we = 1'b1; bus_wdata = loc_data;       end
      S_VCMD:   begin bus_we = 1'b1; bus_wdata = DW'(OP_VERIFY); end
      S_RDMODE: begin bus_we = 1'b1; bus_wdata = DW'(OP_READ);   end
      S_READ:   bus_rd = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/pvs_seq.sv
module pvs_seq
  import pvs_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int LW        = 18,
  parameter int CLK_MHZ   = 200,
  parameter int SETTLE_NS = 6000,
  parameter int MAX_TRIES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] length,
  output logic          src_req,
  output logic [AW-1:0] src_addr,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          bus_we,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam int SETTLE_CYC = (SETTLE_NS * CLK_MHZ + 999) / 1000;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  pvs_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;
  logic [LW-1:0] left_q, left_d;
  logic          left_en;
  logic [DW-1:0] data_q;
  logic          data_en;
  logic          fail_q, fail_d, fail_en;
  logic [AW-1:0] faddr_q;
  logic          faddr_en;
  logic          try_clr, try_inc, try_last;
  logic          tmr_run, tmr_expire;

  pvs_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_q),
    .run    (tmr_run),
    .expire (tmr_expire)
  );

  pvs_try_counter #(.MAX(MAX_TRIES)) u_tries (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (try_clr),
    .inc   (try_inc),
    .last  (try_last)
  );

  pvs_bus_drive #(.AW(AW), .DW(DW)) u_bus (
    .state     (state_q),
    .loc_addr  (addr_q),
    .loc_data  (data_q),
    .bus_we    (bus_we),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

  assign tmr_run = (state_q == S_SETTLE);

  // next state
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    addr_en  = 1'b0;
    left_d   = left_q;
    left_en  = 1'b0;
    data_en  = 1'b0;
    fail_d   = fail_q;
    fail_en  = 1'b0;
    faddr_en = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    src_req  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          fail_d  = 1'b0;
          fail_en = 1'b1;
          addr_d  = base_addr;
          addr_en = 1'b1;
          left_d  = length;
          left_en = 1'b1;
          state_d = (length == '0) ? S_RDMODE : S_FETCH;
        end
      end
      S_FETCH: begin
        src_req = 1'b1;
        if (src_valid) begin
          data_en = 1'b1;
          try_clr = 1'b1;
          state_d = S_SETUP;
        end
      end
      S_SETUP:  state_d = S_PROG;
      S_PROG:   state_d = S_VCMD;
      S_VCMD:   state_d = S_SETTLE;
      S_SETTLE: if (tmr_expire) state_d = S_READ;
      S_READ:   state_d = S_CMP;
      S_CMP: begin
        if (bus_rdata == data_q) begin
          if (left_q == LW'(1)) begin
            state_d = S_RDMODE;
          end else begin
            addr_d  = addr_q + AW'(1);
            addr_en = 1'b1;
            left_d  = left_q - LW'(1);
            left_en = 1'b1;
            state_d = S_FETCH;
          end
        end else if (try_last) begin
          fail_d   = 1'b1;
          fail_en  = 1'b1;
          faddr_en = 1'b1;
          state_d  = S_IDLE;
        end else begin
          try_inc = 1'b1;
          state_d = S_SETUP;
        end
      end
      S_RDMODE: state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      data_q  <= '0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en)  addr_q  <= addr_d;
      if (left_en)  left_q  <= left_d;
      if (data_en)  data_q  <= src_data;
      if (fail_en)  fail_q  <= fail_d;
      if (faddr_en) faddr_q <= addr_q;
    end
  end

  assign src_addr  = addr_q;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign fail      = fail_q;
  assign fail_addr = faddr_q;

  // R2: verify command right after the program write
  p_vcmd_follows_prog_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == S_PROG) |=> (bus_we && bus_wdata == DW'(OP_VERIFY)));
  // R3: a read only once the settle window has run out
  p_read_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_q)
    bus_rd |-> $past(tmr_expire));
  // R4: one source transfer per request
  p_src_once_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (src_req && src_valid) |=> !src_req);
  // R6: a failure is held until a new start
  p_fail_hold_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (fail && !start) |=> fail);
  // R6: an idle sequencer leaves the bus alone
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !busy |-> (!bus_we && !bus_rd));
  // R7: done is preceded by the read-mode write
  p_done_after_rdmode_r7: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> $past(bus_we && bus_wdata == DW'(OP_READ)));

endmodule

// File: tb/sim_pvs_seq.sv
`timescale 1ns/1ps
module sim_pvs_seq;
  localparam int AW = 6, DW = 8, LW = 7, CLK_MHZ = 200, TRIES = 25;
  localparam int SETTLE = (6000 * CLK_MHZ + 999) / 1000;
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] length = '0;
  logic src_req, src_valid, bus_we, bus_rd, busy, done, fail;
  logic [AW-1:0] src_addr, bus_addr, fail_addr;
  logic [DW-1:0] src_data, bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  pvs_seq #(.AW(AW), .DW(DW), .LW(LW), .CLK_MHZ(CLK_MHZ), .MAX_TRIES(TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .length(length),
    .src_req(src_req), .src_addr(src_addr), .src_valid(src_valid), .src_data(src_data),
    .bus_we(bus_we), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr));

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 29 + 60) & 255);
  endfunction

  // flash and source models; per-run counters clear on an accepted start
  logic [7:0] mem [NLOC];
  int bad_plan [NLOC];
  int prog_cnt [NLOC];
  int src_cnt  [NLOC];
  int wr_cnt, done_cnt, proto_err, gap_err, prev_pa;
  longint cyc, c0_cyc;
  logic [7:0] last_wdata;
  bit exp_prog, in_vfy, after_prog, first_pa;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < NLOC; i++) mem[i] = 8'hFF;
      src_valid <= 1'b0;
      bus_rdata <= '0;
    end
    if (start && !busy) begin
      for (int i = 0; i < NLOC; i++) begin prog_cnt[i] = 0; src_cnt[i] = 0; end
      wr_cnt = 0; done_cnt = 0; proto_err = 0; gap_err = 0; first_pa = 1;
    end
    src_valid <= src_req && !src_valid;
    src_data  <= pattern(int'(src_addr));
    if (src_req && !src_valid) src_cnt[src_addr]++;
    if (done) done_cnt++;
    if (bus_we) begin
      wr_cnt++;
      last_wdata = bus_wdata;
      if (exp_prog) begin
        if (!first_pa && int'(bus_addr) != prev_pa && int'(bus_addr) != prev_pa + 1)
          proto_err++;
        first_pa = 0;
        prev_pa = int'(bus_addr);
        mem[bus_addr] = (prog_cnt[bus_addr] < bad_plan[bus_addr]) ? (bus_wdata ^ 8'h5A) : bus_wdata;
        prog_cnt[bus_addr]++;
        exp_prog = 0; after_prog = 1; in_vfy = 0;
      end else begin
        case (bus_wdata)
          8'h40: begin exp_prog = 1; in_vfy = 0; end
          8'hC0: begin if (!after_prog) proto_err++; in_vfy = 1; c0_cyc = cyc; end
          8'h00: in_vfy = 0;
          default: proto_err++;
        endcase
        after_prog = 0;
      end
    end else if (exp_prog || after_prog) begin
      proto_err++;
      exp_prog = 0; after_prog = 0;
    end
    if (bus_rd) begin
      bus_rdata <= mem[bus_addr];
      if (!in_vfy) proto_err++;
      if (cyc - c0_cyc != longint'(SETTLE + 1)) gap_err++;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 40000) begin @(negedge clk); n++; end
    chk(!busy, "R6", "run finished in time", int'(busy), 0);
  endtask

  task automatic go(input int b, input int len);
    @(negedge clk);
    base_addr = AW'(b); length = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "R6", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    for (int i = 0; i < NLOC; i++) bad_plan[i] = 0;
    exp_prog = 0; in_vfy = 0; after_prog = 0; first_pa = 1; prev_pa = 0;
    cyc = 0; c0_cyc = 0; wr_cnt = 0; done_cnt = 0; proto_err = 0; gap_err = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fail && !src_req && !bus_we && !bus_rd, "R10", "outputs in reset",
        int'({busy, done, fail, src_req, bus_we, bus_rd}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fail && !bus_we && !bus_rd, "R10", "outputs after reset",
        int'({busy, done, fail, bus_we, bus_rd}), 0);

    // clean run of 8 locations
    go(3, 8);
    for (int i = 3; i < 11; i++) begin
      chk(mem[i] == pattern(i), "R1", "stored byte", int'(mem[i]), int'(pattern(i)));
      chk(prog_cnt[i] == 1, "R4", "program writes per passing location", prog_cnt[i], 1);
      chk(src_cnt[i] == 1, "R4", "source requests per location", src_cnt[i], 1);
    end
    chk(mem[2] == 8'hFF && mem[11] == 8'hFF, "R1", "neighbours untouched", int'(mem[11]), 255);
    chk(wr_cnt == 8 * 3 + 1, "R1", "bus writes in run", wr_cnt, 25);
    chk(proto_err == 0, "R2", "command order errors", proto_err, 0);
    chk(gap_err == 0, "R3", "verify-to-read distance errors", gap_err, 0);
    chk(done_cnt == 1, "R7", "done cycles", done_cnt, 1);
    chk(last_wdata == 8'h00, "R7", "last write is read mode", int'(last_wdata), 0);
    chk(!fail, "R6", "fail after clean run", int'(fail), 0);

    // three failed programs in the middle
    bad_plan[20] = 3;
    go(19, 3);
    chk(prog_cnt[20] == 4, "R5", "attempts at retried location", prog_cnt[20], 4);
    chk(prog_cnt[19] == 1 && prog_cnt[21] == 1, "R4", "neighbours pass once", prog_cnt[21], 1);
    chk(src_cnt[20] == 1, "R4", "no refetch on retry", src_cnt[20], 1);
    chk(mem[20] == pattern(20), "R5", "retried byte", int'(mem[20]), int'(pattern(20)));
    chk(wr_cnt == 6 * 3 + 1, "R5", "bus writes with retries", wr_cnt, 19);
    chk(proto_err == 0 && gap_err == 0, "R3", "order/settle errors with retries", proto_err + gap_err, 0);
    chk(done_cnt == 1, "R7", "done after retries", done_cnt, 1);

    // last permitted attempt succeeds
    bad_plan[30] = TRIES - 1;
    go(30, 1);
    chk(prog_cnt[30] == TRIES, "R5", "attempts at limit", prog_cnt[30], TRIES);
    chk(!fail && done_cnt == 1, "R5", "pass on final attempt", int'(fail), 0);
    chk(mem[30] == pattern(30), "R5", "byte after final attempt", int'(mem[30]), int'(pattern(30)));

    // never verifies
    bad_plan[40] = 99;
    go(39, 3);
    chk(fail, "R6", "fail flag", int'(fail), 1);
    chk(fail_addr == AW'(40), "R6", "failing address", int'(fail_addr), 40);
    chk(prog_cnt[40] == TRIES, "R6", "attempts before giving up", prog_cnt[40], TRIES);
    chk(prog_cnt[41] == 0 && src_cnt[41] == 0, "R6", "next location not visited", prog_cnt[41], 0);
    chk(done_cnt == 0, "R6", "no done on failure", done_cnt, 0);
    chk(wr_cnt == 3 + 3 * TRIES, "R6", "no read-mode write on failure", wr_cnt, 3 + 3 * TRIES);
    repeat (50) @(negedge clk);
    chk(fail && wr_cnt == 3 + 3 * TRIES, "R6", "fail held, bus quiet", wr_cnt, 3 + 3 * TRIES);

    // empty run
    go(50, 0);
    chk(!fail, "R6", "fail cleared by start", int'(fail), 0);
    chk(wr_cnt == 1 && last_wdata == 8'h00, "R8", "only read-mode write", wr_cnt, 1);
    chk(done_cnt == 1, "R8", "done on empty run", done_cnt, 1);
    chk(prog_cnt[50] == 0, "R8", "nothing programmed", prog_cnt[50], 0);

    // start while busy
    @(negedge clk);
    base_addr = AW'(5); length = LW'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    base_addr = AW'(60); length = LW'(1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(prog_cnt[5] == 1 && prog_cnt[6] == 1, "R9", "original run completed", prog_cnt[6], 1);
    chk(prog_cnt[60] == 0 && mem[60] == 8'hFF, "R9", "busy start ignored", int'(mem[60]), 255);
    chk(done_cnt == 1, "R9", "single done", done_cnt, 1);

    finish_up();
  end
endmodule